// File: doc/BRIEF.md
# Radio Coexistence Signalling Arbiter

This block sits between a short-range radio baseband and the four shared signalling lines that connect it to a WLAN transceiver on the same board. Each cycle the baseband states whether it wants the air for the current slot, at what priority and in which direction. The block applies one of five software-selected arbitration schemes, tells the baseband whether it may go ahead, and drives or releases the coexistence lines as that scheme requires.

The lines share four GPIO pads with other functions. The first pair also carries I2C clock and data. The second pair also carries two extra PCM frame-sync outputs. The block reports the function of each pad on a routing map for the pad multiplexer. The scheme select is taken up only while the radio is idle, so a grant that is in progress is never cut short by a change of scheme. The one input the schemes read (line 1) is resynchronised before use.

Top module: `coex_arbiter`

## Requirements
- R1: After reset the arbitration scheme (code 0) is active, `grant` is low and `line_out` is all zero. With both pairs enabled, `line_oe` is 4'b1110.
- R2: Under the arbitration scheme (code 0), line 2 (`line_out[1]`) drives the request, line 3 (`line_out[2]`) drives priority and line 4 (`line_out[3]`) drives the transmit direction. Each follows the registered `act_req`, `act_pri & act_req` and `act_tx & act_req`, and changes one clock edge after the input.
- R3: `wl_in` (line 1) passes through SYNC_STAGES flops. `grant` is a register, so a change on `wl_in` reaches `grant` SYNC_STAGES+1 edges later. `grant` is never high in the cycle after `act_req` was low.
- R4: Under code 0, `grant` is `act_req` AND the synchronised confirm. Once the confirm is seen low during a request, `grant` stays low until `act_req` has dropped, even if the confirm returns high.
- R5: Under WLAN-master (code 1), `grant` is `act_req` AND NOT the synchronised `wl_in`, and no line is driven.
- R6: Under radio-master (code 2), `grant` follows `act_req` regardless of `wl_in`. Only line 2 is driven, and it carries the registered request.
- R7: Under two-wire (code 3), line 2 is always driven. If `host_master` is 1 the radio is master: the code 2 rule applies and line 2 carries the request. If `host_master` is 0 the WLAN is master: the code 1 rule applies and line 2 is driven low.
- R8: Under alternating access (code 4), `grant` is `act_req` AND the synchronised `wl_in` (medium free), and no line is driven.
- R9: Select codes 5 to 7 are ignored, and the previously active scheme stays in force.
- R10: A new `alg_sel` or `host_master` value is taken up only on an edge where `act_req` is low and `grant` is low. While a grant is held, the scheme and the driven lines do not change.
- R11: `coex_en[0]` gates the output enables of lines 1-2, and `coex_en[1]` gates those of lines 3-4. A line whose output enable is low has `line_out` at 0.
- R12: `gpio_fn` holds 2 bits per pad, with pad 0 in bits [1:0]. The code is 1 (coexistence) if the pair's `coex_en` bit is set. Otherwise it is 2 (I2C for pads 0-1, PCM sync for pads 2-3) if the pair's `alt_en` bit is set. Otherwise it is 0 (plain GPIO). Both pads of a pair always carry the same code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | 1 | Baseband wants the air this slot |
| act_pri | input | 1 | Request is high priority |
| act_tx | input | 1 | Request is a transmission |
| alg_sel | input | 3 | Arbitration scheme code 0..4 |
| host_master | input | 1 | Two-wire scheme: 1 = radio master, 0 = WLAN master |
| coex_en | input | 2 | Per pair: pads used for coexistence |
| alt_en | input | 2 | Per pair: pads used for the alternate function |
| wl_in | input | 1 | Line 1 input from the WLAN side (asynchronous) |
| line_out | output | 4 | Drive values of lines 1..4 (bit 0 = line 1) |
| line_oe | output | 4 | Output enables of lines 1..4 |
| grant | output | 1 | Radio may use the air |
| gpio_fn | output | 8 | Pad function map, 2 bits per pad |

## Verification
The hardest situation to bring about is a scheme change requested while a grant is held. The bench holds a grant under one scheme and moves `alg_sel` to another. It then watches the lines and `grant` stay put for several cycles, drops the request, and sees the new scheme appear only once grant has fallen. The sticky denial is reached in a similar way: the confirm is held low at the start of a request and raised mid-request. The main sweep covers every scheme, master choice, line level, priority and direction, and each point starts from an idle state so that every scheme change is taken up.

// File: rtl/coex_pkg.sv
package coex_pkg;

    typedef enum logic [2:0] {
        ALG_ARB          = 3'd0,
        ALG_WL_MASTER    = 3'd1,
        ALG_RADIO_MASTER = 3'd2,
        ALG_TWO_WIRE     = 3'd3,
        ALG_ALTERNATE    = 3'd4
    } alg_e;

    typedef enum logic [1:0] {
        FN_GPIO = 2'd0,
        FN_COEX = 2'd1,
        FN_ALT  = 2'd2
    } pinfn_e;

    typedef struct packed {
        alg_e alg;
        logic master;
        logic req;
        logic pri;
        logic tx;
        logic grant;
        logic deny;
    } arb_state_t;

    function automatic logic alg_code_ok(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/coex_sync.sv
module coex_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/coex_pinmap.sv
module coex_pinmap
    import coex_pkg::*;
#(
    parameter int PAIRS = 2
) (
    input  logic [PAIRS-1:0]   coex_en,
    input  logic [PAIRS-1:0]   alt_en,
    output logic [4*PAIRS-1:0] fn
);
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic [1:0] sel;
        assign sel = coex_en[p] ? FN_COEX : (alt_en[p] ? FN_ALT : FN_GPIO);
        assign fn[4*p +: 4] = {sel, sel};
    end
endmodule

// File: rtl/coex_arbiter.sv
module coex_arbiter
    import coex_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_req,
    input  logic       act_pri,
    input  logic       act_tx,
    input  logic [2:0] alg_sel,
    input  logic       host_master,
    input  logic [1:0] coex_en,
    input  logic [1:0] alt_en,
    input  logic       wl_in,
    output logic [3:0] line_out,
    output logic [3:0] line_oe,
    output logic       grant,
    output logic [7:0] gpio_fn
);
    localparam int LINES = 4;
    localparam int PAIRS = LINES / 2;

    arb_state_t st_d, st_q;
    logic       wl_s;
    logic       go;
    logic       idle;
    logic [LINES-1:0] drv, en, en_g;

    coex_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wl_in),
        .q     (wl_s)
    );

    coex_pinmap #(.PAIRS(PAIRS)) u_pinmap (
        .coex_en (coex_en),
        .alt_en  (alt_en),
        .fn      (gpio_fn)
    );

    always_comb begin
        st_d = st_q;
        idle = !act_req && !st_q.grant;
        if (idle && alg_code_ok(alg_sel)) begin
            st_d.alg    = alg_e'(alg_sel);
            st_d.master = host_master;
        end
        st_d.req  = act_req;
        st_d.pri  = act_pri & act_req;
        st_d.tx   = act_tx & act_req;
        st_d.deny = 1'b0;

        go  = 1'b0;
        drv = '0;
        en  = '0;
        case (st_q.alg)
            ALG_ARB: begin
                go        = wl_s & ~st_q.deny;
                st_d.deny = act_req & (st_q.deny | ~wl_s);
                en        = 4'b1110;
                drv       = {st_q.tx, st_q.pri, st_q.req, 1'b0};
            end
            ALG_WL_MASTER: begin
                go = ~wl_s;
            end
            ALG_RADIO_MASTER: begin
                go  = 1'b1;
                en  = 4'b0010;
                drv = {2'b00, st_q.req, 1'b0};
            end
            ALG_TWO_WIRE: begin
                go  = st_q.master ? 1'b1 : ~wl_s;
                en  = 4'b0010;
                drv = {2'b00, st_q.req & st_q.master, 1'b0};
            end
            ALG_ALTERNATE: begin
                go = wl_s;
            end
            default: begin
                go = 1'b0;
            end
        endcase
        st_d.grant = act_req & go;

        for (int p = 0; p < PAIRS; p++) begin
            en_g[2*p +: 2] = en[2*p +: 2] & {2{coex_en[p]}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{alg: ALG_ARB, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign line_oe  = en_g;
    assign line_out = drv & en_g;
    assign grant    = st_q.grant;
endmodule

// File: rtl/coex_arbiter_chk.sv
module coex_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       act_req,
    input logic [1:0] coex_en,
    input logic [3:0] line_out,
    input logic [3:0] line_oe,
    input logic       grant,
    input logic [7:0] gpio_fn
);
    AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(act_req)); // R3

    AST_GRANT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !act_req |=> !grant); // R3

    AST_PAIR_A_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !coex_en[0] |-> line_oe[1:0] == 2'b00); // R11

    AST_PAIR_B_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !coex_en[1] |-> line_oe[3:2] == 2'b00); // R11

    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (line_out & ~line_oe) == 4'b0000); // R11

    AST_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        grant && $past(grant) && $stable(coex_en) |-> $stable(line_oe)); // R10

    AST_PAIR_SAME_FN: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_fn[1:0] == gpio_fn[3:2] && gpio_fn[5:4] == gpio_fn[7:6]); // R12
endmodule

bind coex_arbiter coex_arbiter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_req  (act_req),
    .coex_en  (coex_en),
    .line_out (line_out),
    .line_oe  (line_oe),
    .grant    (grant),
    .gpio_fn  (gpio_fn)
);

// File: tb/coex_arbiter_tb.sv
module coex_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       act_req = 1'b0, act_pri = 1'b0, act_tx = 1'b0;
    logic [2:0] alg_sel = 3'd0;
    logic       host_master = 1'b0;
    logic [1:0] coex_en = 2'b11, alt_en = 2'b00;
    logic       wl_in = 1'b0;
    logic [3:0] line_out, line_oe;
    logic       grant;
    logic [7:0] gpio_fn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coex_arbiter #(.SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_pri(act_pri),
        .act_tx(act_tx), .alg_sel(alg_sel), .host_master(host_master),
        .coex_en(coex_en), .alt_en(alt_en), .wl_in(wl_in),
        .line_out(line_out), .line_oe(line_oe), .grant(grant), .gpio_fn(gpio_fn)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1", "grant", grant, 0);
        chk("R1", "line_out", line_out, 4'b0000);
        chk("R1", "line_oe", line_oe, 4'b1110);

        // R12 pad map sweep
        for (int ce = 0; ce < 4; ce++) begin
            for (int ae = 0; ae < 4; ae++) begin
                logic [1:0] fa, fb;
                coex_en = 2'(ce); alt_en = 2'(ae);
                #1;
                fa = coex_en[0] ? 2'd1 : (alt_en[0] ? 2'd2 : 2'd0);
                fb = coex_en[1] ? 2'd1 : (alt_en[1] ? 2'd2 : 2'd0);
                chk("R12", "gpio_fn", gpio_fn, {fb, fb, fa, fa});
            end
        end
        coex_en = 2'b11; alt_en = 2'b00;

        // R2 one-edge latency of the request line, code 0
        wl_in = 1'b1; step(5);
        act_req = 1'b1; act_pri = 1'b1; #1;
        chk("R2", "line2 before edge", line_out[1], 0);
        step(1);
        chk("R2", "line2 after edge", line_out[1], 1);
        chk("R2", "line3 priority", line_out[2], 1);
        chk("R4", "grant with confirm", grant, 1);
        act_req = 1'b0; act_pri = 1'b0; step(3);

        // R4 sticky denial
        wl_in = 1'b0; step(4);
        act_req = 1'b1; step(3);
        chk("R4", "grant denied", grant, 0);
        wl_in = 1'b1; step(5);
        chk("R4", "denial held after confirm returns", grant, 0);
        act_req = 1'b0; step(2);
        act_req = 1'b1; step(1);
        chk("R4", "grant on next request", grant, 1);
        act_req = 1'b0; step(3);

        // R3 / R5 synchroniser latency under code 1
        alg_sel = 3'd1; wl_in = 1'b0; step(4);
        act_req = 1'b1; step(2);
        chk("R5", "grant while WLAN quiet", grant, 1);
        wl_in = 1'b1; step(SYNC);
        chk("R3", "grant before sync delay", grant, 1);
        step(1);
        chk("R3", "grant after sync delay", grant, 0);
        chk("R5", "no line driven", line_oe, 4'b0000);

        // R10 scheme change held off while granted
        wl_in = 1'b0; step(4);
        chk("R10", "grant held", grant, 1);
        alg_sel = 3'd2; step(5);
        chk("R10", "oe unchanged mid-grant", line_oe, 4'b0000);
        chk("R10", "grant unchanged mid-grant", grant, 1);
        act_req = 1'b0; step(3);
        chk("R10", "new scheme after idle", line_oe, 4'b0010);

        // R9 invalid code ignored
        alg_sel = 3'd6; step(3);
        chk("R9", "oe after code 6", line_oe, 4'b0010);
        wl_in = 1'b1; act_req = 1'b1; step(4);
        chk("R9", "grant stays radio-master", grant, 1);
        act_req = 1'b0; step(3);

        // R11 per-pair gating under code 0
        alg_sel = 3'd0; step(3);
        act_pri = 1'b1; act_tx = 1'b1;
        coex_en = 2'b01; act_req = 1'b1; step(2);
        chk("R11", "oe pair A only", line_oe, 4'b0010);
        chk("R11", "out pair A only", line_out, 4'b0010);
        act_req = 1'b0; step(3);
        coex_en = 2'b10; act_req = 1'b1; step(2);
        chk("R11", "oe pair B only", line_oe, 4'b1100);
        chk("R11", "out pair B only", line_out, 4'b1100);
        act_req = 1'b0; step(3);
        coex_en = 2'b00; act_req = 1'b1; step(2);
        chk("R11", "oe none", line_oe, 4'b0000);
        chk("R11", "out none", line_out, 4'b0000);
        act_req = 1'b0; coex_en = 2'b11; step(3);

        // Main sweep over schemes and inputs (R2, R5, R6, R7, R8)
        for (int a = 0; a < 5; a++) begin
            for (int hm = 0; hm < 2; hm++) begin
                for (int wl = 0; wl < 2; wl++) begin
                    for (int pt = 0; pt < 4; pt++) begin
                        logic eg;
                        logic [3:0] eoe, eout;
                        string rq;
                        act_req = 1'b0; step(3);
                        alg_sel = 3'(a); host_master = hm[0]; wl_in = wl[0];
                        act_pri = pt[0]; act_tx = pt[1];
                        step(4);
                        act_req = 1'b1; step(3);
                        case (a)
                            0: begin eg = wl[0]; eoe = 4'b1110;
                                     eout = {pt[1], pt[0], 1'b1, 1'b0}; rq = "R2"; end
                            1: begin eg = !wl[0]; eoe = 4'b0000; eout = 4'b0000; rq = "R5"; end
                            2: begin eg = 1'b1; eoe = 4'b0010; eout = 4'b0010; rq = "R6"; end
                            3: begin eg = hm[0] ? 1'b1 : !wl[0]; eoe = 4'b0010;
                                     eout = {2'b00, hm[0], 1'b0}; rq = "R7"; end
                            default: begin eg = wl[0]; eoe = 4'b0000; eout = 4'b0000; rq = "R8"; end
                        endcase
                        chk(rq, "grant", grant, eg);
                        chk(rq, "line_oe", line_oe, eoe);
                        chk(rq, "line_out", line_out, eout);
                    end
                end
            end
        end
        act_req = 1'b0; step(3);
        finish_run();
    end
endmodule